// File: doc/BRIEF.md
# Mode-Switched Parallel Port Register Front End

This block is the host-facing register decoder of an extended-capabilities parallel port. A simple bus supplies an address offset, one-cycle read and write strobes and a byte of write data. A 3-bit operating mode, held in the top bits of the extended control register, selects which internal resource each offset reaches. Depending on the mode, an offset can reach the plain output data latch, the shared 16-entry FIFO (as a command byte or as a data byte), the configuration registers, or nothing at all.

Each FIFO entry is nine bits wide. The top bit is a tag that tells the downstream peripheral engine whether the byte is a command/address byte or a data byte. The engine sees the head entry on its own port. It can remove that entry, and it can also add bytes in the reverse direction. In test mode the host can write and read the FIFO directly, so the FIFO loops back to the host. Any change of mode empties the FIFO.

Top module: `ppi_regfront`

## Requirements
- R1: After reset, rdata, data_out and ctrl_out are 0x00, configuration register B holds 0x00, the FIFO is empty, and the extended control register reads 0x01 (mode 000).
- R2: A read strobe loads rdata on the same clock edge that samples it. rdata holds its value in every cycle that has no read strobe. The offsets are: 0x000 data, 0x001 status, 0x002 control, 0x400 FIFO or configuration A, 0x401 configuration B, 0x402 extended control.
- R3: In modes 000 and 001, offset 0x000 is a read/write data latch, and the latch drives data_out.
- R4: In every mode, offset 0x001 returns status_in and ignores writes. Offset 0x002 is a read/write control register that drives ctrl_out.
- R5: The extended control register at 0x402 is writable in every mode. Its bits 7:5 are the mode and bits 4:2 are plain storage. Bit 1 (FIFO full) and bit 0 (FIFO empty) are read-only.
- R6: Writing a mode value that differs from the current mode empties the FIFO. Rewriting the current mode keeps the FIFO contents.
- R7: A write to 0x400 in modes 010, 011 and 110 stores the byte with tag 0. A write to 0x000 in mode 011 stores the byte with tag 1. eng_head shows {tag, byte}, with the tag in bit 8.
- R8: The FIFO keeps first-in first-out order for up to 16 entries. A write while the FIFO is full is dropped.
- R9: A host read of the FIFO (0x400 in modes 010, 011 and 110, or 0x000 in mode 011) returns the head byte and removes it. A read of an empty FIFO returns 0xFF and changes nothing.
- R10: In mode 110, bytes the host writes at 0x400 read back at 0x400 in the same order.
- R11: In mode 111, offset 0x400 reads the constant CFG_A (default 0x10) and ignores writes. Offset 0x401 is read/write in mode 111 only.
- R12: An offset that the current mode does not map reads 0xFF, and a write to it changes no state.
- R13: eng_push adds a byte with tag 0 unless the host writes the FIFO in the same cycle. eng_pop removes the head entry unless the host reads the FIFO in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| status_in | input | 8 | Live status bits shown at 0x001 |
| ctrl_out | output | 8 | Control register contents |
| data_out | output | 8 | Data latch contents |
| eng_head | output | 9 | FIFO head entry {tag, byte} |
| eng_empty | output | 1 | FIFO empty |
| eng_full | output | 1 | FIFO full |
| eng_pop | input | 1 | Engine removes the head entry |
| eng_push | input | 1 | Engine adds a byte |
| eng_wdata | input | 8 | Engine byte to add |

## Verification
Several properties are checked on every cycle by the assertions: unmapped reads return 0xFF, configuration A always reads its constant, status reads follow the status input, and a mode change leaves the FIFO empty. They also check that the FIFO count never exceeds its depth and that a full FIFO stays full when the only request is a write. Other behaviour can only be shown by the bench's scenarios. These include FIFO ordering and loopback, the tag value chosen by the write path, rewriting the current mode without loss of data, the ignored writes, and the priority of the host over the engine.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  localparam logic [2:0] MD_SPP  = 3'b000;
  localparam logic [2:0] MD_BIDI = 3'b001;
  localparam logic [2:0] MD_PFIFO = 3'b010;
  localparam logic [2:0] MD_ECP  = 3'b011;
  localparam logic [2:0] MD_TEST = 3'b110;
  localparam logic [2:0] MD_CFG  = 3'b111;

  localparam int OFS_DATA = 'h000;
  localparam int OFS_STAT = 'h001;
  localparam int OFS_CTRL = 'h002;
  localparam int OFS_FIFO = 'h400;
  localparam int OFS_CFGB = 'h401;
  localparam int OFS_ECR  = 'h402;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DATA, SEL_STAT, SEL_CTRL, SEL_FCMD,
    SEL_FDAT, SEL_CFGA, SEL_CFGB, SEL_ECR
  } sel_t;
endpackage

// File: rtl/ppi_fifo.sv
module ppi_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = PW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          push_ok, pop_ok;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign push_ok = push && !full && !clr;
  assign pop_ok  = pop && !empty && !clr;
  assign head    = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop_ok)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));  // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    full && push && !pop && !clr |=> full);  // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    empty && pop && !push |=> empty);  // R9
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clr |=> empty);  // R6
endmodule

// File: rtl/ppi_decode.sv
module ppi_decode
  import ppi_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        mode,
  output sel_t              sel
);
  always_comb begin
    sel = SEL_NONE;
    if (addr == ADDR_W'(OFS_DATA)) begin
      if (mode == MD_SPP || mode == MD_BIDI) sel = SEL_DATA;
      else if (mode == MD_ECP)               sel = SEL_FCMD;
    end else if (addr == ADDR_W'(OFS_STAT)) begin
      sel = SEL_STAT;
    end else if (addr == ADDR_W'(OFS_CTRL)) begin
      sel = SEL_CTRL;
    end else if (addr == ADDR_W'(OFS_FIFO)) begin
      if (mode == MD_PFIFO || mode == MD_ECP || mode == MD_TEST) sel = SEL_FDAT;
      else if (mode == MD_CFG)                                    sel = SEL_CFGA;
    end else if (addr == ADDR_W'(OFS_CFGB)) begin
      if (mode == MD_CFG) sel = SEL_CFGB;
    end else if (addr == ADDR_W'(OFS_ECR)) begin
      sel = SEL_ECR;
    end
  end
endmodule

// File: rtl/ppi_regfront.sv
module ppi_regfront
  import ppi_pkg::*;
#(
  parameter int          ADDR_W = 11,
  parameter int          DEPTH  = 16,
  parameter logic [7:0]  CFG_A  = 8'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [7:0]        status_in,
  output logic [7:0]        ctrl_out,
  output logic [7:0]        data_out,
  output logic [8:0]        eng_head,
  output logic              eng_empty,
  output logic              eng_full,
  input  logic              eng_pop,
  input  logic              eng_push,
  input  logic [7:0]        eng_wdata
);
  sel_t       sel;
  logic [2:0] mode_q;
  logic [2:0] ecr_spare_q;
  logic [7:0] cfgb_q;
  logic       fifo_sel, host_push, host_pop, mode_chg;
  logic       f_push, f_pop;
  logic [8:0] f_wdata;
  logic [7:0] rd_val;

  ppi_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .mode(mode_q), .sel(sel)
  );

  assign fifo_sel  = (sel == SEL_FCMD) || (sel == SEL_FDAT);
  assign host_push = wr_en && fifo_sel;
  assign host_pop  = rd_en && fifo_sel;
  assign mode_chg  = wr_en && (sel == SEL_ECR) && (wdata[7:5] != mode_q);
  assign f_push    = host_push || eng_push;
  assign f_pop     = host_pop || eng_pop;
  assign f_wdata   = host_push ? {(sel == SEL_FCMD), wdata} : {1'b0, eng_wdata};

  ppi_fifo #(.DEPTH(DEPTH), .W(9)) u_fifo (
    .clk(clk), .rst(rst), .clr(mode_chg), .push(f_push), .pop(f_pop),
    .wdata(f_wdata), .head(eng_head), .empty(eng_empty), .full(eng_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q      <= MD_SPP;
      ecr_spare_q <= '0;
      cfgb_q      <= '0;
      ctrl_out    <= '0;
      data_out    <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_DATA: data_out <= wdata;
        SEL_CTRL: ctrl_out <= wdata;
        SEL_CFGB: cfgb_q   <= wdata;
        SEL_ECR: begin
          mode_q      <= wdata[7:5];
          ecr_spare_q <= wdata[4:2];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_DATA:           rd_val = data_out;
      SEL_STAT:           rd_val = status_in;
      SEL_CTRL:           rd_val = ctrl_out;
      SEL_FCMD, SEL_FDAT: rd_val = eng_empty ? 8'hFF : eng_head[7:0];
      SEL_CFGA:           rd_val = CFG_A;
      SEL_CFGB:           rd_val = cfgb_q;
      SEL_ECR:            rd_val = {mode_q, ecr_spare_q, eng_full, eng_empty};
      default:            rd_val = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end

  AST_UNMAPPED_FF: assert property (@(posedge clk) disable iff (rst)
    rd_en && sel == SEL_NONE |=> rdata == 8'hFF);  // R12
  AST_CFGA_CONST: assert property (@(posedge clk) disable iff (rst)
    rd_en && sel == SEL_CFGA |=> rdata == CFG_A);  // R11
  AST_STATUS_LIVE: assert property (@(posedge clk) disable iff (rst)
    rd_en && sel == SEL_STAT |=> rdata == $past(status_in));  // R4
  AST_MODE_FLUSH: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> eng_empty);  // R6
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));  // R2
endmodule

// File: tb/tb_ppi_regfront.sv
module tb_ppi_regfront;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wdata = '0, status_in = '0, eng_wdata = '0;
  logic        eng_pop = 1'b0, eng_push = 1'b0;
  logic [7:0]  rdata, ctrl_out, data_out;
  logic [8:0]  eng_head;
  logic        eng_empty, eng_full;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  ppi_regfront dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .status_in(status_in), .ctrl_out(ctrl_out),
    .data_out(data_out), .eng_head(eng_head), .eng_empty(eng_empty),
    .eng_full(eng_full), .eng_pop(eng_pop), .eng_push(eng_push),
    .eng_wdata(eng_wdata)
  );

  // {is_write, offset, write data, expected read}
  localparam int NV = 22;
  localparam logic [27:0] VEC [NV] = '{
    {1'b1, 11'h000, 8'hA5, 8'h00},  // R3 latch write
    {1'b0, 11'h000, 8'h00, 8'hA5},  // R3
    {1'b1, 11'h002, 8'h3C, 8'h00},  // R4 control
    {1'b0, 11'h002, 8'h00, 8'h3C},  // R4
    {1'b1, 11'h401, 8'h77, 8'h00},  // R12 cfgB write in 000 ignored
    {1'b0, 11'h401, 8'h00, 8'hFF},  // R12
    {1'b0, 11'h400, 8'h00, 8'hFF},  // R12
    {1'b1, 11'h402, 8'h40, 8'h00},  // R5 mode 010
    {1'b0, 11'h402, 8'h00, 8'h41},  // R5
    {1'b1, 11'h400, 8'h11, 8'h00},  // R7
    {1'b1, 11'h400, 8'h22, 8'h00},  // R7
    {1'b0, 11'h402, 8'h00, 8'h40},  // R5 not empty
    {1'b0, 11'h400, 8'h00, 8'h11},  // R8 order
    {1'b0, 11'h400, 8'h00, 8'h22},  // R8
    {1'b0, 11'h400, 8'h00, 8'hFF},  // R9 empty read
    {1'b0, 11'h000, 8'h00, 8'hFF},  // R12 data in 010
    {1'b1, 11'h402, 8'hE0, 8'h00},  // R11 mode 111
    {1'b0, 11'h400, 8'h00, 8'h10},  // R11 cfgA
    {1'b0, 11'h401, 8'h00, 8'h00},  // R11 earlier write lost
    {1'b1, 11'h401, 8'h5A, 8'h00},  // R11
    {1'b0, 11'h401, 8'h00, 8'h5A},  // R11
    {1'b0, 11'h000, 8'h00, 8'hFF}   // R12
  };

  task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [10:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rdata", {8'h0, rdata}, 16'h0000);
    chk("R1 data_out", {8'h0, data_out}, 16'h0000);
    chk("R1 ctrl_out", {8'h0, ctrl_out}, 16'h0000);
    chk("R1 empty", {15'h0, eng_empty}, 16'h0001);
    rd(11'h402, r); chk("R1 ecr", {8'h0, r}, 16'h0001);
    @(negedge clk);
    chk("R2 rdata held", {8'h0, rdata}, 16'h0001);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][27]) wr(VEC[i][26:16], VEC[i][15:8]);
      else begin
        rd(VEC[i][26:16], r);
        chk($sformatf("R2 vector %0d", i), {8'h0, r}, {8'h0, VEC[i][7:0]});
      end
    end

    // R11 cfgA ignores writes
    wr(11'h400, 8'hEE); rd(11'h400, r); chk("R11 cfgA write", {8'h0, r}, 16'h0010);

    // R4 status follows input, write ignored
    status_in = 8'h9C; wr(11'h001, 8'h00); rd(11'h001, r);
    chk("R4 status", {8'h0, r}, 16'h009C);

    // R7 tags in mode 011, R13 engine pop
    wr(11'h402, 8'h60);
    wr(11'h000, 8'hC1); wr(11'h400, 8'hD2);
    chk("R7 cmd tag", {7'h0, eng_head}, 16'h01C1);
    @(negedge clk); eng_pop = 1'b1; @(negedge clk); eng_pop = 1'b0;
    chk("R7 data tag", {7'h0, eng_head}, 16'h00D2);
    rd(11'h000, r); chk("R9 read at 0x000 in 011", {8'h0, r}, 16'h00D2);

    // R8/R10 fill in test mode
    wr(11'h402, 8'hC0);
    for (int i = 0; i < 16; i++) wr(11'h400, 8'(i * 7 + 3));
    rd(11'h402, r); chk("R8 full flag", {8'h0, r}, 16'h00C2);
    wr(11'h400, 8'h99);
    for (int i = 0; i < 16; i++) begin
      rd(11'h400, r); chk("R10 loopback", {8'h0, r}, {8'h0, 8'(i * 7 + 3)});
    end
    rd(11'h400, r); chk("R8 dropped write", {8'h0, r}, 16'h00FF);

    // R6 same mode keeps, new mode clears
    wr(11'h400, 8'h01); wr(11'h400, 8'h02);
    wr(11'h402, 8'hC0);
    rd(11'h402, r); chk("R6 same mode keeps", {8'h0, r}, 16'h00C0);
    wr(11'h402, 8'h5C);
    rd(11'h402, r); chk("R6 R5 mode change clears", {8'h0, r}, 16'h005D);

    // R13 engine push, tag 0, host reads it
    @(negedge clk); eng_wdata = 8'h7E; eng_push = 1'b1;
    @(negedge clk); eng_push = 1'b0;
    chk("R13 engine push", {7'h0, eng_head}, 16'h007E);
    rd(11'h400, r); chk("R13 host read", {8'h0, r}, 16'h007E);

    // R13 host write has priority over engine push
    @(negedge clk); addr = 11'h400; wdata = 8'h31; wr_en = 1'b1;
    eng_wdata = 8'h44; eng_push = 1'b1;
    @(negedge clk); wr_en = 1'b0; eng_push = 1'b0;
    rd(11'h400, r); chk("R13 host first", {8'h0, r}, 16'h0031);
    chk("R13 engine byte dropped", {15'h0, eng_empty}, 16'h0001);

    // R3 latch in mode 001
    wr(11'h402, 8'h20); wr(11'h000, 8'h6B);
    chk("R3 data_out", {8'h0, data_out}, 16'h006B);
    finish_run();
  end
endmodule